// File: doc/BRIEF.md
# Sparse GPIO Bank Register File

This block is a small memory-mapped register file that governs a bank of general-purpose pins through a single-cycle 32-bit register port. Three registers live in it: a use-select register that hands each pin to either software control (1) or its native function (0), a direction register where 1 means input and 0 means output, and a level register that both sets the driven value of output pins and reports the sampled state of input pins.

Of the 32 bit positions, only ten carry a pin: bits 17:16 and 7:0. All others are tied to zero and drop writes. Input pins are passed through a two-flop synchronizer before they appear in the level read-back. Level writes reach only pins that are software-owned outputs. Writes to input pins or native pins are dropped, and native pins read back as 0.

A write takes effect on the rising clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `gpio_sparse_bank`

## Requirements
- R1: After reset, the use-select register reads 00000000h, the direction register reads 000000F0h, and the level register reads 00000000h because every pin is native. Also after reset, `pin_out` equals 00030003h and `pin_oe` is 0.
- R2: Only bit positions 17:16 and 7:0 (mask 000300FFh) hold state. Every other bit of every register reads as 0 and ignores writes, and those bits of `pin_out` and `pin_oe` are always 0.
- R3: The use-select register is at byte offset 30h, the direction register at 34h and the level register at 38h. A read of any other offset returns 0, and a write to any other offset changes no register.
- R4: For each implemented bit, `pin_oe[i]` is 1 exactly when use-select bit i is 1 and direction bit i is 0.
- R5: A level write sets bit i of the stored level for every pin whose use-select bit is 1 and whose direction bit is 0, judged before the write. `pin_out` shows the new value from the clock edge of the write. For such a pin, a level read returns the stored bit.
- R6: For a pin with use-select 1 and direction 1, a level write leaves its stored level and `pin_out` bit unchanged. Its level read bit returns `pin_in[i]` through two flops: a change on `pin_in` is not visible after one rising edge and is visible after the second.
- R7: For a pin with use-select 0, a level write leaves its stored level and `pin_out` bit unchanged, and its level read bit returns 0.
- R8: Turning an input pin back into an output drives the level stored before it became an input. The sampled input value is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the offset on `bus_addr` |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on `bus_addr` |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Driven value per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
Two things can happen in the same cycle: a level write that targets an input pin, and a change of that pin's input arriving at the synchronizer. To provoke this, the bench toggles `pin_in[0]` in the same cycle as it writes the opposite value to the level register while bit 0 is an input. The read-back is judged two edges later and must show the synchronized pin value. `pin_out` bit 0 is judged too and must keep its old stored value. A vector table also mixes level writes across output, input and native pins in the same write, so that the per-pin blocking rule is checked bit by bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [DATA_W-1:0] IMPL_MASK = 32'h0003_00FF;
  localparam logic [DATA_W-1:0] RST_USE   = 32'h0000_0000;
  localparam logic [DATA_W-1:0] RST_DIR   = 32'h0000_00F0;
  localparam logic [DATA_W-1:0] RST_LVL   = 32'h0003_0003;

  localparam logic [ADDR_W-1:0] OFF_USE = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_DIR = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_LVL = 8'h38;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_USE  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_LVL  = 2'd3
  } reg_sel_e;

  // A level write reaches a pin only when software owns it as an output.
  function automatic logic lvl_write_ok(input logic use_b, input logic dir_b);
    return use_b & ~dir_b;
  endfunction

  // Read-back of one level bit: native reads 0, input shows the synced pin.
  function automatic logic lvl_read_bit(input logic use_b, input logic dir_b,
                                        input logic lvl_b, input logic sin_b);
    if (!use_b) return 1'b0;
    return dir_b ? sin_b : lvl_b;
  endfunction
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  output reg_sel_e      sel,
  output logic          we_use,
  output logic          we_dir,
  output logic          we_lvl
);
  always_comb begin
    unique case (bus_addr)
      OFF_USE: sel = SEL_USE;
      OFF_DIR: sel = SEL_DIR;
      OFF_LVL: sel = SEL_LVL;
      default: sel = SEL_NONE;
    endcase
  end

  assign we_use = bus_wr && (sel == SEL_USE);
  assign we_dir = bus_wr && (sel == SEL_DIR);
  assign we_lvl = bus_wr && (sel == SEL_LVL);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
#(
  parameter logic USE_INIT = 1'b0,
  parameter logic DIR_INIT = 1'b1,
  parameter logic LVL_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_use,
  input  logic we_dir,
  input  logic we_lvl,
  input  logic wbit,
  input  logic sync_in,
  output logic use_o,
  output logic dir_o,
  output logic lvl_o,
  output logic lvl_rd_o,
  output logic oe_o,
  output logic wr_ok_o
);
  logic use_q, dir_q, lvl_q;

  assign wr_ok_o = lvl_write_ok(use_q, dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= USE_INIT;
      dir_q <= DIR_INIT;
      lvl_q <= LVL_INIT;
    end else begin
      if (we_use) use_q <= wbit;
      if (we_dir) dir_q <= wbit;
      if (we_lvl && wr_ok_o) lvl_q <= wbit;
    end
  end

  assign use_o    = use_q;
  assign dir_o    = dir_q;
  assign lvl_o    = lvl_q;
  assign oe_o     = use_q & ~dir_q;
  assign lvl_rd_o = lvl_read_bit(use_q, dir_q, lvl_q, sync_in);
endmodule

// File: rtl/gpio_sparse_bank.sv
module gpio_sparse_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned          DW   = DATA_W,
  parameter int unsigned          AW   = ADDR_W,
  parameter logic [DATA_W-1:0]    MASK = IMPL_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe
);
  reg_sel_e      sel;
  logic          we_use, we_dir, we_lvl;

  // Named internal state, brought out for the checker.
  logic [DW-1:0] use_q, dir_q, lvl_q, lvl_rd, sync_in, wr_allow;

  gpio_reg_decode #(.AW(AW)) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .sel     (sel),
    .we_use  (we_use),
    .we_dir  (we_dir),
    .we_lvl  (we_lvl)
  );

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      gpio_in_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in[i]),
        .sync_out(sync_in[i])
      );
      gpio_pin_cell #(
        .USE_INIT(RST_USE[i]),
        .DIR_INIT(RST_DIR[i]),
        .LVL_INIT(RST_LVL[i])
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_use  (we_use),
        .we_dir  (we_dir),
        .we_lvl  (we_lvl),
        .wbit    (bus_wdata[i]),
        .sync_in (sync_in[i]),
        .use_o   (use_q[i]),
        .dir_o   (dir_q[i]),
        .lvl_o   (lvl_q[i]),
        .lvl_rd_o(lvl_rd[i]),
        .oe_o    (pin_oe[i]),
        .wr_ok_o (wr_allow[i])
      );
    end else begin : g_tied
      assign sync_in[i]  = 1'b0;
      assign use_q[i]    = 1'b0;
      assign dir_q[i]    = 1'b0;
      assign lvl_q[i]    = 1'b0;
      assign lvl_rd[i]   = 1'b0;
      assign pin_oe[i]   = 1'b0;
      assign wr_allow[i] = 1'b0;
    end
  end

  assign pin_out = lvl_q;

  always_comb begin
    unique case (sel)
      SEL_USE: bus_rdata = use_q;
      SEL_DIR: bus_rdata = dir_q;
      SEL_LVL: bus_rdata = lvl_rd;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sparse_bank_chk.sv
module gpio_sparse_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned       DW   = DATA_W,
  parameter int unsigned       AW   = ADDR_W,
  parameter logic [DATA_W-1:0] MASK = IMPL_MASK
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] pin_out,
  input logic [DW-1:0] pin_oe,
  input logic [DW-1:0] use_q,
  input logic [DW-1:0] dir_q,
  input logic [DW-1:0] wr_allow
);
  wire lvl_hit = bus_wr && (bus_addr == OFF_LVL);
  wire mapped  = (bus_addr == OFF_USE) || (bus_addr == OFF_DIR) || (bus_addr == OFF_LVL);

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata | pin_out | pin_oe) & ~MASK) == '0);

  assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);

  assert_oe_needs_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & (dir_q | ~use_q)) == '0);

  assert_other_writes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_hit |=> $stable(pin_out));

  assert_blocked_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hit |=> ((pin_out ^ $past(pin_out)) & ~$past(wr_allow)) == '0);

  assert_native_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_LVL) |-> (bus_rdata & ~use_q) == '0);
endmodule

bind gpio_sparse_bank gpio_sparse_bank_chk #(.DW(DW), .AW(AW), .MASK(MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .use_q    (use_q),
  .dir_q    (dir_q),
  .wr_allow (wr_allow)
);

// File: tb/gpio_sparse_bank_tb.sv
module gpio_sparse_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_sparse_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Step: write W_DATA to W_ADDR, then read R_ADDR and expect R_EXP.
  localparam int NV = 12;
  localparam logic [7:0]  W_ADDR [NV] = '{8'h30, 8'h34, 8'h38, 8'h34, 8'h38, 8'h38,
                                          8'h30, 8'h38, 8'h40, 8'h3C, 8'h34, 8'h38};
  localparam logic [31:0] W_DATA [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000,
                                          32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_005A,
                                          32'h0000_000F, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0000};
  localparam logic [7:0]  R_ADDR [NV] = '{8'h30, 8'h34, 8'h38, 8'h34, 8'h38, 8'h38,
                                          8'h30, 8'h38, 8'h40, 8'h30, 8'h34, 8'h38};
  localparam logic [31:0] R_EXP  [NV] = '{32'h0003_00FF, 32'h0003_00FF, 32'h0002_00A5,
                                          32'h0000_0000, 32'h0003_00FF, 32'h0001_005A,
                                          32'h0000_000F, 32'h0000_000F, 32'h0000_0000,
                                          32'h0000_000F, 32'h0000_0003, 32'h0000_0001};
  localparam string       V_REQ  [NV] = '{"R2", "R2", "R6", "R4", "R5", "R5",
                                          "R3", "R7", "R3", "R3", "R2", "R6"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_check("R1", 8'h30, 32'h0000_0000);
    rd_check("R1", 8'h34, 32'h0000_00F0);
    rd_check("R1", 8'h38, 32'h0000_0000);
    check("R1", pin_out, 32'h0003_0003);
    check("R1", pin_oe, 32'h0000_0000);

    pin_in = 32'h0002_00A5;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      wr(W_ADDR[k], W_DATA[k]);
      rd_check(V_REQ[k], R_ADDR[k], R_EXP[k]);
    end
    // Stored level 00010053; bits 3:0 GPIO, 1:0 input, 3:2 output.
    check("R5", pin_out, 32'h0001_0053);
    check("R4", pin_oe, 32'h0000_000C);

    // R8: inputs back to outputs drive the stored level, not the sample.
    pin_in = 32'h0;
    wr(8'h34, 32'h0);
    rd_check("R8", 8'h38, 32'h0000_0003);
    check("R8", pin_out, 32'h0001_0053);
    check("R4", pin_oe, 32'h0000_000F);

    // R6: two-flop latency; bit 0 input, pin low and settled.
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h1);
    repeat (3) @(negedge clk);
    bus_addr = 8'h38;
    pin_in[0] = 1'b1;
    @(negedge clk); #1;
    check("R6", bus_rdata, 32'h0);
    @(negedge clk); #1;
    check("R6", bus_rdata, 32'h1);

    // Same cycle: pin drops while a level write of 1 targets bit 0 (input).
    @(negedge clk);
    pin_in[0] = 1'b0;
    bus_addr = 8'h38; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; #1;
    check("R6", bus_rdata, 32'h1);
    @(negedge clk); #1;
    check("R6", bus_rdata, 32'h0);
    check("R6", pin_out, 32'h0001_0053);

    // R7: native bits ignore level writes.
    wr(8'h38, 32'h0000_0000);
    check("R7", pin_out, 32'h0001_0053);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule